// File: doc/BRIEF.md
# Quad-Channel Modem Control and Interrupt Gating

This block holds the modem-side control and status registers for four serial channels that share one 8-bit processor bus. Each channel has its own active-low select. The processor writes a control register that drives the channel's active-low DTR, RTS and OUT1 lines and carries an interrupt-enable bit. It reads a status register that reports the four modem inputs, together with change flags for those inputs.

Each channel receives one interrupt request bit and presents an interrupt value with an output-enable, so that a pad can tri-state the line. A single strap input sets the policy. With the strap low, each channel's enable follows its own OUT2 bit. With the strap high, every enable is forced on. An unconnected strap must be tied low at board level, which gives the low-strap behaviour.

Top module: `quad_modem_ctl`

## Requirements
- R1: A write reaches every channel whose select is low, and no other channel. A read returns data from the lowest-numbered selected channel.
- R2: The control register is at address 4 and holds bits [3:0]. Written bits [7:4] are dropped, and it reads back with bits [7:4] at zero. A write to any other address leaves every output unchanged.
- R3: Control bit 0 drives dtr_n, bit 1 drives rts_n and bit 2 drives out1_n, each low while its bit is set. The outputs update on the clock edge that takes the write.
- R4: While rst is high, every control register is cleared: dtr_n, rts_n and out1_n all read high, and with the strap low every irq_oe is low.
- R5: The status register is at address 6. Bit 4 reports CTS, bit 5 DSR, bit 6 RI and bit 7 DCD. A bit reads 1 while its pin is low, and a pin change appears on the second clock edge after it.
- R6: Status bit 0 flags a CTS change, bit 1 a DSR change and bit 3 a DCD change. Bit 2 flags RI returning from low to high. Each flag is set on the same edge on which the level bit updates.
- R7: Reading a channel's status register clears that channel's flags on the read's clock edge. A flag that is being set on that same edge stays set. Reads of another address or another channel leave the flags intact.
- R8: With the strap low, irq_oe of a channel equals its control bit 3. irq_val always equals irq_req.
- R9: With the strap high, every irq_oe is 1 whatever the control bits hold.
- R10: The CTS and DSR inputs have no effect on dtr_n, rts_n, out1_n, irq_val or irq_oe.
- R11: rdata is zero when rd_en is low, when no select is low, or when the address is neither 4 nor 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous master reset, active high |
| cs_n | input | 4 | Per-channel select, active low |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| cts_n | input | 4 | Clear-to-send inputs, active low |
| dsr_n | input | 4 | Data-set-ready inputs, active low |
| ri_n | input | 4 | Ring indicator inputs, active low |
| dcd_n | input | 4 | Carrier detect inputs, active low |
| dtr_n | output | 4 | Data-terminal-ready outputs, active low |
| rts_n | output | 4 | Request-to-send outputs, active low |
| out1_n | output | 4 | General-purpose outputs, active low |
| int_strap | input | 1 | Interrupt policy strap (tie low when unused) |
| irq_req | input | 4 | Per-channel interrupt requests |
| irq_val | output | 4 | Interrupt values |
| irq_oe | output | 4 | Interrupt output enables (0 means high impedance) |

## Verification
Three latencies matter. Control outputs move on the single edge that takes a write. rdata and the interrupt outputs are combinational. Modem levels and flags become visible two edges after a pin change. The bench drives all inputs on falling edges. It checks control outputs one falling edge after a write, and samples reads and interrupt outputs 1 ns after their inputs settle. For modem inputs it reads once after one edge, expecting no change yet, and again after the second edge. That second read lands on the edge that sets the flag, which also confirms that setting wins over the read-clear.

// File: rtl/quad_modem_ctl.sv
module quad_modem_ctl #(
  parameter int NCH = 4,
  parameter logic [2:0] CTRL_ADDR = 3'd4,
  parameter logic [2:0] STAT_ADDR = 3'd6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cs_n,
  input  logic [2:0]     addr,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  input  logic [NCH-1:0] cts_n,
  input  logic [NCH-1:0] dsr_n,
  input  logic [NCH-1:0] ri_n,
  input  logic [NCH-1:0] dcd_n,
  output logic [NCH-1:0] dtr_n,
  output logic [NCH-1:0] rts_n,
  output logic [NCH-1:0] out1_n,
  input  logic           int_strap,
  input  logic [NCH-1:0] irq_req,
  output logic [NCH-1:0] irq_val,
  output logic [NCH-1:0] irq_oe
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [3:0] ctrl_w [NCH];
  logic [3:0] lvl_w  [NCH];
  logic [3:0] flag_w [NCH];
  logic [CW-1:0] rch;
  logic          rhit;

  always_comb begin
    rhit = 1'b0;
    rch  = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (!cs_n[i]) begin
        rhit = 1'b1;
        rch  = CW'(i);
      end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && rhit) begin
      if (addr == CTRL_ADDR)      rdata = {4'h0, ctrl_w[rch]};
      else if (addr == STAT_ADDR) rdata = {lvl_w[rch], flag_w[rch]};
    end
  end

  assign irq_val = irq_req;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [3:0] ctrl_q, sync_a, sync_b, flag_q, flag_set;
    logic       wr_hit, clr;

    assign wr_hit = wr_en && !cs_n[ch] && (addr == CTRL_ADDR);
    assign clr    = rd_en && rhit && (rch == CW'(ch)) && (addr == STAT_ADDR);
    assign flag_set = {sync_a[3] ^ sync_b[3], sync_b[2] & ~sync_a[2],
                       sync_a[1] ^ sync_b[1], sync_a[0] ^ sync_b[0]};

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        ctrl_q <= '0;
        sync_a <= '0;
        sync_b <= '0;
        flag_q <= '0;
      end else begin
        if (wr_hit) ctrl_q <= wdata[3:0];
        sync_a <= ~{dcd_n[ch], ri_n[ch], dsr_n[ch], cts_n[ch]};
        sync_b <= sync_a;
        flag_q <= (clr ? 4'h0 : flag_q) | flag_set;
      end
    end

    assign ctrl_w[ch] = ctrl_q;
    assign lvl_w[ch]  = sync_b;
    assign flag_w[ch] = flag_q;
    assign dtr_n[ch]  = ~ctrl_q[0];
    assign rts_n[ch]  = ~ctrl_q[1];
    assign out1_n[ch] = ~ctrl_q[2];
    assign irq_oe[ch] = int_strap | ctrl_q[3];

    p_write_dtr_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !cs_n[ch] && addr == CTRL_ADDR) |=> (dtr_n[ch] == !$past(wdata[0])));

    p_unsel_hold_r1: assert property (@(posedge clk) disable iff (rst)
      (!wr_en || cs_n[ch]) |=> ($stable(dtr_n[ch]) && $stable(rts_n[ch]) && $stable(out1_n[ch])));

    p_oe_out2_r8: assert property (@(posedge clk) disable iff (rst)
      (!int_strap && $past(wr_en && !cs_n[ch] && addr == CTRL_ADDR)) |-> (irq_oe[ch] == $past(wdata[3])));
  end

  p_dtr_reset_r4: assert property (@(posedge clk) rst |=> (dtr_n == '1 && rts_n == '1 && out1_n == '1));

  p_strap_oe_r9: assert property (@(posedge clk) disable iff (rst)
    int_strap |-> (irq_oe == '1));

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || cs_n == '1) |-> (rdata == 8'h00));
endmodule

// File: tb/quad_modem_ctl_bench.sv
module quad_modem_ctl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cs_n = 4'hF;
  logic [2:0] addr = 3'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] cts_n = 4'hF, dsr_n = 4'hF, ri_n = 4'hF, dcd_n = 4'hF;
  logic [3:0] dtr_n, rts_n, out1_n;
  logic       int_strap = 1'b0;
  logic [3:0] irq_req = 4'h0;
  logic [3:0] irq_val, irq_oe;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  quad_modem_ctl u_quad_modem_ctl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dcd_n(dcd_n), .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n),
    .int_strap(int_strap), .irq_req(irq_req), .irq_val(irq_val), .irq_oe(irq_oe)
  );

  // {cs_n, addr, wdata, exp dtr_n, exp rts_n, exp out1_n, exp irq_oe}
  localparam logic [30:0] VEC [8] = '{
    {4'b1110, 3'd4, 8'h0F, 4'b1110, 4'b1110, 4'b1110, 4'b0001},
    {4'b1101, 3'd4, 8'h05, 4'b1100, 4'b1110, 4'b1100, 4'b0001},
    {4'b1011, 3'd4, 8'h0A, 4'b1100, 4'b1010, 4'b1100, 4'b0101},
    {4'b0111, 3'd4, 8'hF8, 4'b1100, 4'b1010, 4'b1100, 4'b1101},
    {4'b1110, 3'd5, 8'h00, 4'b1100, 4'b1010, 4'b1100, 4'b1101},
    {4'b1111, 3'd4, 8'h00, 4'b1100, 4'b1010, 4'b1100, 4'b1101},
    {4'b1110, 3'd4, 8'h02, 4'b1101, 4'b1010, 4'b1101, 4'b1100},
    {4'b1001, 3'd4, 8'h01, 4'b1001, 4'b1110, 4'b1111, 4'b1000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] cs, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = cs; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cs_n = 4'hF;
  endtask

  task automatic do_read(input logic [3:0] cs, input logic [2:0] a, output logic [7:0] d);
    cs_n = cs; addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0; cs_n = 4'hF;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R4 reset dtr/rts/out1", {dtr_n, rts_n, out1_n}, 12'hFFF);
    chk("R4 reset irq_oe", irq_oe, 4'h0);
    rst = 1'b0;
    @(negedge clk);
    do_read(4'b1110, 3'd6, d);
    chk("R5 status idle", d, 8'h00);

    for (int i = 0; i < 8; i++) begin
      do_write(VEC[i][30:27], VEC[i][26:24], VEC[i][23:16]);
      chk($sformatf("R1 R2 R3 vec%0d dtr", i), dtr_n, VEC[i][15:12]);
      chk($sformatf("R3 vec%0d rts", i), rts_n, VEC[i][11:8]);
      chk($sformatf("R3 vec%0d out1", i), out1_n, VEC[i][7:4]);
      chk($sformatf("R8 vec%0d oe", i), irq_oe, VEC[i][3:0]);
    end

    do_read(4'b1110, 3'd4, d); chk("R2 readback ch0", d, 8'h02);
    do_read(4'b1101, 3'd4, d); chk("R2 readback ch1", d, 8'h01);
    do_read(4'b1011, 3'd4, d); chk("R2 readback ch2", d, 8'h01);
    do_read(4'b0111, 3'd4, d); chk("R2 readback ch3 upper zero", d, 8'h08);
    do_read(4'b0011, 3'd4, d); chk("R1 multi-select read lowest", d, 8'h01);
    do_read(4'b1111, 3'd4, d); chk("R11 no select", d, 8'h00);
    do_read(4'b1110, 3'd3, d); chk("R11 unmapped addr", d, 8'h00);
    cs_n = 4'b1110; addr = 3'd4; #1;
    chk("R11 rd_en low", rdata, 8'h00);
    @(negedge clk); cs_n = 4'hF;

    cts_n[1] = 1'b0;
    @(negedge clk);
    do_read(4'b1101, 3'd6, d); chk("R5 one edge not yet", d, 8'h00);
    do_read(4'b1101, 3'd6, d); chk("R6 R7 cts flag set wins", d, 8'h11);
    do_read(4'b1101, 3'd6, d); chk("R7 flags cleared", d, 8'h10);
    ri_n[1] = 1'b0;
    repeat (2) @(negedge clk);
    do_read(4'b1101, 3'd6, d); chk("R5 R6 ri leading no flag", d, 8'h50);
    ri_n[1] = 1'b1;
    repeat (2) @(negedge clk);
    do_read(4'b1101, 3'd6, d); chk("R6 ri trailing flag", d, 8'h14);
    dcd_n[2] = 1'b0; dsr_n[2] = 1'b0;
    repeat (2) @(negedge clk);
    do_read(4'b1011, 3'd4, d); chk("R7 other addr read", d, 8'h01);
    do_read(4'b1101, 3'd6, d); chk("R7 other channel isolated", d, 8'h10);
    do_read(4'b1011, 3'd6, d); chk("R5 R6 dcd dsr flags", d, 8'hAA);
    do_read(4'b1011, 3'd6, d); chk("R7 ch2 cleared", d, 8'hA0);

    chk("R10 controls after cts/dsr", {dtr_n, rts_n, out1_n}, 12'h9EF);
    chk("R10 oe after cts/dsr", irq_oe, 4'b1000);

    irq_req = 4'b0101; #1;
    chk("R8 irq_val follows", irq_val, 4'b0101);
    int_strap = 1'b1; #1;
    chk("R9 strap forces oe", irq_oe, 4'hF);
    do_write(4'b0111, 3'd4, 8'h00);
    chk("R9 strap with out2 clear", irq_oe, 4'hF);
    int_strap = 1'b0; #1;
    chk("R8 strap low gated", irq_oe, 4'h0);

    @(negedge clk);
    rst = 1'b1; #1;
    chk("R4 mid-run reset", {dtr_n, rts_n, out1_n}, 12'hFFF);
    @(negedge clk);
    rst = 1'b0;
    do_read(4'b1110, 3'd4, d); chk("R4 control cleared", d, 8'h00);
    finish_run();
  end
endmodule